// File: doc/BRIEF.md
# Re-arming asynchronous serial receiver

This block receives one character at a time from an asynchronous serial line. The bit period is a runtime setting, expressed as a count of system clocks. A polarity input decides which pin level counts as idle. A mode input selects frames with eight or nine data bits. Each character appears on a 9-bit data bus together with a valid strobe that lasts one clock.

The receiver arms only after it has seen the line at the idle level. It then waits for the start level and lets one and a half bit periods pass. After that it samples each data bit once, one bit period apart, least significant bit first. The character is delivered as soon as the last data bit has been taken. The stop bit is neither waited for nor checked. After a frame, the receiver only re-arms once the line has gone back to idle, so a line held at the start level after a frame never produces a second character.

Top module: `serial_rearm_rx`

## Requirements
- R1: After reset, `rx_valid` is 0 and `rx_data` is 0. A line held at the start level from reset onward produces no character, because the receiver has not yet seen idle.
- R2: The pin passes through a two-flop synchronizer. With D = div + floor(div/2), the first data bit is taken from the line value D clocks after the start level was seen. If the start level first appears on the pin before clock edge 1, `rx_valid` is high after edge 3 + D + (n-1)*div, where n is the number of data bits.
- R3: Each later data bit is taken exactly div clocks after the one before it. Only that single clock's line value is used.
- R4: Data bits arrive least significant bit first into `rx_data[0]` upward. When `nine_bit` is 0, eight bits are received and `rx_data[8]` is 0.
- R5: When `nine_bit` is 1, nine data bits are received, and the ninth lands in `rx_data[8]`.
- R6: `rx_valid` is a single-clock pulse, raised right after the last data bit is taken. The stop bit is not checked, so a frame followed by a held start level is still delivered.
- R7: After a frame, and after reset, the receiver accepts a new start level only after the line has been at the idle level. A line that stays at the start level yields no further characters.
- R8: When `invert` is 0, the pin idles high. When `invert` is 1, the pin idles low and every data bit is read from the complemented pin level.
- R9: `bit_clks` may be any value from 1 to 65535, and one clock per bit works. A value of 0 is treated as 1.
- R10: Changes to `bit_clks`, `nine_bit` or `invert` during a frame have no effect on that frame. `bit_clks` and `nine_bit` are captured when the start level is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pin | input | 1 | Asynchronous serial line |
| bit_clks | input | 16 | Clocks per bit (0 behaves as 1) |
| invert | input | 1 | 1 selects low-idle, inverted line |
| nine_bit | input | 1 | 1 selects nine data bits per frame |
| rx_data | output | 9 | Last received character |
| rx_valid | output | 1 | One-clock strobe for a new character |

## Verification
The hardest property to observe from the ports is the exact clock on which each bit is sampled. A normal frame also decodes correctly if the sample point is off by a clock or two. To pin it down, the stimulus drives "strict" frames: each data bit carries its true value only on the one clock the receiver is required to sample, and the complement on every other clock of its period. The re-arm rule is reached with a frame whose last data bit is 0, followed by a held start level several bit periods long. Any retrigger there shows up as an extra character. Mid-frame configuration changes are driven right after the start bit.

// File: rtl/serial_rearm_rx.sv
module serial_rearm_rx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_pin,
  input  logic [DIV_W-1:0] bit_clks,
  input  logic             invert,
  input  logic             nine_bit,
  output logic [8:0]       rx_data,
  output logic             rx_valid
);
  localparam int CNT_W = DIV_W + 1;

  typedef enum logic [1:0] {S_ARM = 2'd0, S_HUNT = 2'd1, S_BITS = 2'd2} state_t;

  state_t           state;
  logic             sync1, sync2;
  logic [DIV_W-1:0] div_q;
  logic             nine_q, inv_q;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       idx;
  logic [8:0]       shreg;
  logic [8:0]       merged;
  logic [DIV_W-1:0] div_eff;
  logic [CNT_W-1:0] first_wait;
  logic             line, bit_now, last_bit;

  assign div_eff    = (bit_clks == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : bit_clks;
  assign first_wait = {1'b0, div_eff} + CNT_W'(div_eff >> 1);
  assign line       = sync2 ^ invert;
  assign bit_now    = sync2 ^ inv_q;
  assign last_bit   = (idx == (nine_q ? 4'd8 : 4'd7));

  always_comb begin
    merged      = shreg;
    merged[idx] = bit_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_ARM;
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      div_q    <= '0;
      nine_q   <= 1'b0;
      inv_q    <= 1'b0;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      sync1    <= rx_pin;
      sync2    <= sync1;
      rx_valid <= 1'b0;
      case (state)
        S_ARM: if (line) state <= S_HUNT;
        S_HUNT: if (!line) begin
          state  <= S_BITS;
          div_q  <= div_eff;
          nine_q <= nine_bit;
          inv_q  <= invert;
          cnt    <= first_wait - CNT_W'(1);
          idx    <= '0;
          shreg  <= '0;
        end
        S_BITS: begin
          if (cnt == '0) begin
            shreg <= merged;
            cnt   <= {1'b0, div_q} - CNT_W'(1);
            idx   <= idx + 4'd1;
            if (last_bit) begin
              rx_data  <= nine_q ? merged : {1'b0, merged[7:0]};
              rx_valid <= 1'b1;
              state    <= S_ARM;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= S_ARM;
      endcase
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(state) == S_BITS);

  a_r7_arm_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HUNT && $past(state) == S_ARM) |-> $past(line));

  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BITS && $past(state) == S_BITS) |->
      ($stable(div_q) && $stable(nine_q) && $stable(inv_q)));

  a_r4_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !nine_q) |-> (rx_data[8] == 1'b0));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BITS) |-> (cnt < ({1'b0, div_q} + CNT_W'(div_q >> 1))));

endmodule

// File: tb/test_serial_rearm_rx.sv
`timescale 1ns/1ps
module test_serial_rearm_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_pin;
  logic [15:0] bit_clks;
  logic        invert;
  logic        nine_bit;
  logic [8:0]  rx_data;
  logic        rx_valid;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int nvalid = 0;
  bit prev_valid = 1'b0;
  bit inv = 1'b0;
  bit done = 1'b0;

  logic [8:0] exp_data[$];
  int         exp_cyc[$];
  string      exp_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_rearm_rx i_serial_rearm_rx (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .bit_clks(bit_clks),
    .invert(invert), .nine_bit(nine_bit), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && rx_valid === 1'b1) begin
      nvalid++;
      check(!prev_valid, "R6", "strobe longer than one clock", 1, 0);
      if (exp_data.size() == 0) begin
        check(1'b0, "R7", "unexpected character", int'(rx_data), 0);
      end else begin
        logic [8:0] d;
        int         c;
        string      t;
        d = exp_data.pop_front();
        c = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        check(rx_data === d, t, "data", int'(rx_data), int'(d));
        check(cyc == c, "R2", "strobe cycle", cyc, c);
      end
    end
    prev_valid = (rx_valid === 1'b1);
  end

  task automatic send_frame(input logic [8:0] val, input int div, input bit nine,
                            input bit strict, input bit brk, input bit mid,
                            input string tag);
    int   eff, d, n, k, start;
    logic lvl;
    eff = (div == 0) ? 1 : div;
    d   = eff + eff / 2;
    n   = nine ? 9 : 8;
    @(negedge clk);
    bit_clks = 16'(div);
    nine_bit = nine;
    rx_pin   = ~inv;
    repeat (2) @(negedge clk);
    start = cyc;
    exp_data.push_back(nine ? val : {1'b0, val[7:0]});
    exp_cyc.push_back(start + 3 + d + (n - 1) * eff);
    exp_tag.push_back(tag);
    for (int c = 0; c < (n + 1) * eff; c++) begin
      if (c < eff) lvl = 1'b0;
      else begin
        k   = (c - eff) / eff;
        lvl = val[k];
        if (strict && c != d + k * eff) lvl = ~lvl;
      end
      if (mid && c == eff) begin
        bit_clks = 16'(eff * 2 + 1);
        nine_bit = ~nine;
      end
      rx_pin = lvl ^ inv;
      @(negedge clk);
    end
    if (brk) begin
      rx_pin = inv;
      repeat (3 * eff + 4) @(negedge clk);
    end
    rx_pin = ~inv;
    repeat (eff) @(negedge clk);
  endtask

  task automatic wait_drain();
    repeat (40) @(negedge clk);
    check(exp_data.size() == 0, "R6", "characters missing", exp_data.size(), 0);
  endtask

  task automatic set_polarity(input bit p);
    @(negedge clk);
    rst_n  = 1'b0;
    inv    = p;
    invert = p;
    rx_pin = ~p;
    repeat (3) @(negedge clk);
    check(rx_valid === 1'b0, "R1", "valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    rst_n    = 1'b0;
    rx_pin   = 1'b0;
    invert   = 1'b0;
    nine_bit = 1'b0;
    bit_clks = 16'd4;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_valid === 1'b0, "R1", "valid after reset", int'(rx_valid), 0);
    check(rx_data === 9'h000, "R1", "data after reset", int'(rx_data), 0);
    repeat (30) @(negedge clk);
    check(nvalid == 0, "R1", "character without idle", nvalid, 0);
    rx_pin = 1'b1;
    repeat (10) @(negedge clk);

    send_frame(9'h0A5, 4, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    send_frame(9'h03C, 4, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    send_frame(9'h0C3, 3, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
    send_frame(9'h05A, 1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
    send_frame(9'h0C3, 1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
    send_frame(9'h096, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    send_frame(9'h1A5, 3, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    send_frame(9'h0FF, 7, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    send_frame(9'h1FF, 5, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    wait_drain();

    send_frame(9'h035, 4, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    wait_drain();
    check(nvalid == 10, "R7", "characters after held start level", nvalid, 10);
    send_frame(9'h081, 4, 1'b0, 1'b0, 1'b0, 1'b0, "R7");

    send_frame(9'h06B, 4, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
    send_frame(9'h14D, 9, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
    send_frame(9'h02D, 300, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    wait_drain();

    set_polarity(1'b1);
    send_frame(9'h071, 5, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    send_frame(9'h12E, 2, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    send_frame(9'h010, 4, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    wait_drain();
    check(nvalid == 17, "R8", "character count inverted", nvalid, 17);

    finish_up();
  end
endmodule